// File: doc/BRIEF.md
# Dual Prescaled Clock Divider Generator

This block produces the rate ticks that pace a bank of PWM channels. Everything runs in the master clock domain. A free-running binary prescaler supplies eleven one-cycle enable pulses, at the master rate divided by 1, 2, 4, up to 1024. Two independent divider clocks, A and B, each pick one of those taps and divide it again by an 8-bit integer. Each emits a one-cycle enable pulse once per completed division.

One 32-bit mode register holds the configuration of both divider clocks. A write to that register restarts only the half whose configuration actually changed. A divisor of zero switches that clock off, and so does an exponent outside the tap range. Downstream counters use `tap_tick`, `tick_a` and `tick_b` as clock enables and never as clocks.

Each divider is a two-state machine. It has the states `DV_OFF` (idle, no pulses) and `DV_RUN` (counting selected tap pulses). It has three transitions, each taken on a write that changes its half:
- **arm** moves `DV_OFF` to `DV_RUN` when the new configuration is valid.
- **disarm** moves `DV_RUN` to `DV_OFF` when it is not valid.
- **restart** keeps `DV_RUN` and clears the count.

Top module: `pwm_clk_gen`

## Requirements
- R1: During reset and after it, every tap output and both divider outputs are low. Neither divider pulses until the mode register is given a valid configuration.
- R2: Tap k (k = 0..10, bit k of `tap_tick`) is a one-cycle pulse that repeats every 2^k master cycles. Whenever tap k is high, tap k-1 is high as well.
- R3: A write takes effect only when `cfg_addr` is 0. Bits 15:0 configure clock A and bits 31:16 configure clock B. Within a half, bits 7:0 are the divisor and bits 11:8 are the tap exponent. Bits 15:12 of a half are ignored: a write that changes only those bits neither restarts nor alters that clock.
- R4: With divisor d (1..255) and exponent e (0..10), the clock pulses every d * 2^e master cycles.
- R5: A half whose divisor is 0, or whose exponent is above 10, produces no pulses.
- R6: A write that changes a half's divisor or exponent restarts that divider from a zero count, and no pulse is emitted on the write edge. With exponent 0 and divisor d, the first pulse follows the d-th rising edge after the edge that captures the write.
- R7: A write that leaves a half's divisor and exponent unchanged does not disturb that clock's pulse spacing.
- R8: A write with a nonzero `cfg_addr` changes nothing.
- R9: A divider output is never high in two consecutive cycles, unless its divisor is 1 and its exponent is 0. In that case it is high every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address; only 0 selects the mode register |
| cfg_wdata | input | 32 | Register write data |
| tap_tick | output | 11 | Prescaler enable pulses; bit k repeats every 2^k cycles |
| tick_a | output | 1 | Divider clock A enable pulse |
| tick_b | output | 1 | Divider clock B enable pulse |

## Verification
The hardest case to reach from the ports is a write that lands while one clock is mid-period and must leave that clock's phase untouched while the other half restarts. A second such case is a write that differs only in the ignored upper bits of a half. The driver waits until every expected pulse gap has been consumed, then writes a word that repeats one half exactly (or only flips its spare bits) and changes the other. The scoreboard keeps measuring the untouched clock's gaps straight across the write, and expects a fresh, restart-timed first gap from the changed clock. Long periods at exponent 10 and divisor 255 show that the top prescaler taps and the full divisor range are carried correctly.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
package clkgen_pkg;

    // Default geometry of the generator.
    localparam int DEF_NTAP   = 11;
    localparam int DEF_DIV_W  = 8;
    localparam int DEF_EXP_W  = 4;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_ADDR_W = 8;

    // Divider control state.
    typedef enum logic {
        DV_OFF = 1'b0,
        DV_RUN = 1'b1
    } dv_state_e;

endpackage

// File: rtl/tick_prescaler.sv
`timescale 1ns/1ps
module tick_prescaler #(
    parameter int NTAP = clkgen_pkg::DEF_NTAP
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [NTAP-1:0] taps
);
    localparam int CW = (NTAP > 1) ? NTAP - 1 : 1;

    logic [CW-1:0]   pcnt;
    logic [NTAP-1:0] tap_nxt;

    // Tap k fires when the low k bits of the counter are all ones.
    assign tap_nxt[0] = 1'b1;
    for (genvar k = 1; k < NTAP; k++) begin : g_tap
        assign tap_nxt[k] = &pcnt[k-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
            taps <= '0;
        end else begin
            pcnt <= pcnt + CW'(1);
            taps <= tap_nxt;
        end
    end
endmodule

// File: rtl/clkgen_mode_reg.sv
`timescale 1ns/1ps
module clkgen_mode_reg #(
    parameter int DATA_W   = clkgen_pkg::DEF_DATA_W,
    parameter int ADDR_W   = clkgen_pkg::DEF_ADDR_W,
    parameter int DIV_W    = clkgen_pkg::DEF_DIV_W,
    parameter int EXP_W    = clkgen_pkg::DEF_EXP_W,
    parameter int REG_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DIV_W-1:0]  div_q   [2],
    output logic [EXP_W-1:0]  exp_q   [2],
    output logic [DIV_W-1:0]  div_new [2],
    output logic [EXP_W-1:0]  exp_new [2],
    output logic [1:0]        chg
);
    localparam int HALF_W = DATA_W / 2;
    localparam int FLD_W  = DIV_W + EXP_W;

    logic hit;
    assign hit = we && (addr == ADDR_W'(REG_ADDR));

    // Field extraction and change detection per half.
    always_comb begin
        for (int h = 0; h < 2; h++) begin
            div_new[h] = wdata[h*HALF_W +: DIV_W];
            exp_new[h] = wdata[h*HALF_W + DIV_W +: EXP_W];
            chg[h]     = hit && ((div_new[h] != div_q[h]) || (exp_new[h] != exp_q[h]));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int h = 0; h < 2; h++) begin
                div_q[h] <= '0;
                exp_q[h] <= '0;
            end
        end else begin
            for (int h = 0; h < 2; h++) begin
                if (chg[h]) begin
                    div_q[h] <= div_new[h];
                    exp_q[h] <= exp_new[h];
                end
            end
        end
    end

    // Spare bits above the fields of each half carry no function.
    for (genvar h = 0; h < 2; h++) begin : g_spare
        if (HALF_W > FLD_W) begin : g_has
            logic unused_spare;
            assign unused_spare = ^wdata[h*HALF_W + FLD_W +: HALF_W - FLD_W];
        end
    end
endmodule

// File: rtl/tick_divider.sv
`timescale 1ns/1ps
module tick_divider
    import clkgen_pkg::*;
#(
    parameter int NTAP  = DEF_NTAP,
    parameter int DIV_W = DEF_DIV_W,
    parameter int EXP_W = DEF_EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTAP-1:0]  taps,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic [EXP_W-1:0] exp_cfg,
    input  logic             load,
    input  logic [DIV_W-1:0] div_new,
    input  logic [EXP_W-1:0] exp_new,
    output logic             tick
);
    dv_state_e        state, state_nxt;
    logic [DIV_W-1:0] count;
    logic             sel;
    logic             new_ok;
    logic             wrap;

    assign new_ok = (div_new != '0) && (int'(exp_new) < NTAP);
    assign wrap   = (count == div_cfg - DIV_W'(1));

    // Pick the prescaler tap named by the stored exponent.
    always_comb begin
        sel = 1'b0;
        for (int k = 0; k < NTAP; k++) begin
            if (int'(exp_cfg) == k) sel = taps[k];
        end
    end

    // Next-state logic: arm, disarm, restart.
    always_comb begin
        state_nxt = state;
        unique case (state)
            DV_OFF: if (load && new_ok)  state_nxt = DV_RUN;
            DV_RUN: if (load && !new_ok) state_nxt = DV_OFF;
            default: state_nxt = DV_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= DV_OFF;
        else        state <= state_nxt;
    end

    // Count and output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            tick  <= 1'b0;
        end else if (load) begin
            count <= '0;
            tick  <= 1'b0;
        end else begin
            unique case (state)
                DV_RUN: begin
                    if (sel) begin
                        if (wrap) begin
                            count <= '0;
                            tick  <= 1'b1;
                        end else begin
                            count <= count + DIV_W'(1);
                            tick  <= 1'b0;
                        end
                    end else begin
                        tick <= 1'b0;
                    end
                end
                default: begin
                    count <= '0;
                    tick  <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/pwm_clk_gen.sv
`timescale 1ns/1ps
module pwm_clk_gen
    import clkgen_pkg::*;
#(
    parameter int NTAP     = DEF_NTAP,
    parameter int DIV_W    = DEF_DIV_W,
    parameter int EXP_W    = DEF_EXP_W,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int REG_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [NTAP-1:0]   tap_tick,
    output logic              tick_a,
    output logic              tick_b
);
    logic [DIV_W-1:0] div_q   [2];
    logic [EXP_W-1:0] exp_q   [2];
    logic [DIV_W-1:0] div_new [2];
    logic [EXP_W-1:0] exp_new [2];
    logic [1:0]       chg;
    logic [1:0]       ticks;

    tick_prescaler #(.NTAP(NTAP)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (tap_tick)
    );

    clkgen_mode_reg #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .DIV_W    (DIV_W),
        .EXP_W    (EXP_W),
        .REG_ADDR (REG_ADDR)
    ) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .div_q   (div_q),
        .exp_q   (exp_q),
        .div_new (div_new),
        .exp_new (exp_new),
        .chg     (chg)
    );

    for (genvar h = 0; h < 2; h++) begin : g_div
        tick_divider #(
            .NTAP  (NTAP),
            .DIV_W (DIV_W),
            .EXP_W (EXP_W)
        ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .taps    (tap_tick),
            .div_cfg (div_q[h]),
            .exp_cfg (exp_q[h]),
            .load    (chg[h]),
            .div_new (div_new[h]),
            .exp_new (exp_new[h]),
            .tick    (ticks[h])
        );
    end

    assign tick_a = ticks[0];
    assign tick_b = ticks[1];
endmodule

// File: rtl/clkgen_chk.sv
`timescale 1ns/1ps
module clkgen_chk #(
    parameter int NTAP     = 11,
    parameter int DIV_W    = 8,
    parameter int EXP_W    = 4,
    parameter int ADDR_W   = 8,
    parameter int REG_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [NTAP-1:0]   tap_tick,
    input logic              tick_a,
    input logic              tick_b,
    input logic [DIV_W-1:0]  div_a,
    input logic [EXP_W-1:0]  exp_a,
    input logic [DIV_W-1:0]  div_b,
    input logic [EXP_W-1:0]  exp_b,
    input logic              chg_a,
    input logic              chg_b
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tap_tick == '0 && !tick_a && !tick_b)); // R1

    for (genvar k = 1; k < NTAP; k++) begin : g_tap
        AST_TAP_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
            tap_tick[k] |-> tap_tick[k-1]); // R2
        AST_TAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            tap_tick[k] |=> !tap_tick[k]); // R2
    end

    AST_OFF_SILENT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (div_a == '0 || int'(exp_a) >= NTAP) |-> !tick_a); // R5
    AST_OFF_SILENT_B: assert property (@(posedge clk) disable iff (!rst_n)
        (div_b == '0 || int'(exp_b) >= NTAP) |-> !tick_b); // R5

    AST_RESTART_A: assert property (@(posedge clk) disable iff (!rst_n)
        chg_a |=> !tick_a); // R6
    AST_RESTART_B: assert property (@(posedge clk) disable iff (!rst_n)
        chg_b |=> !tick_b); // R6

    AST_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr != ADDR_W'(REG_ADDR)) |=> $stable({div_a, exp_a, div_b, exp_b})); // R8

    AST_PULSE_A: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_a && $past(tick_a)) |-> (div_a == DIV_W'(1) && exp_a == '0)); // R9
    AST_PULSE_B: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_b && $past(tick_b)) |-> (div_b == DIV_W'(1) && exp_b == '0)); // R9
endmodule

bind pwm_clk_gen clkgen_chk #(
    .NTAP     (NTAP),
    .DIV_W    (DIV_W),
    .EXP_W    (EXP_W),
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .tap_tick (tap_tick),
    .tick_a   (tick_a),
    .tick_b   (tick_b),
    .div_a    (div_q[0]),
    .exp_a    (exp_q[0]),
    .div_b    (div_q[1]),
    .exp_b    (exp_q[1]),
    .chg_a    (chg[0]),
    .chg_b    (chg[1])
);

// File: tb/sim_pwm_clk_gen.sv
`timescale 1ns/1ps
module sim_pwm_clk_gen;
    localparam int NTAP = 11;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [7:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [NTAP-1:0] tap_tick;
    logic        tick_a;
    logic        tick_b;

    always #4 clk = ~clk;

    pwm_clk_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .tap_tick  (tap_tick),
        .tick_a    (tick_a),
        .tick_b    (tick_b)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_a = 0, last_b = 0, tot_a = 0, tot_b = 0;
    int gap_a, gap_b;
    // Expected gaps: positive = exact, negative = upper bound (1..-v).
    int    qa[$], qb[$];
    string ta[$], tb[$];
    int tlast [NTAP];
    int tseen [NTAP];
    logic [7:0] m_div [2];
    logic [3:0] m_exp [2];

    task automatic judge(input string tag, input int g, input int e, input string who);
        n_chk++;
        if (e > 0) begin
            if (g != e) begin
                n_fail++;
                $display("FAIL %s %s: gap %0d expected %0d", tag, who, g, e);
            end
        end else if (g < 1 || g > -e) begin
            n_fail++;
            $display("FAIL %s %s: first gap %0d expected 1..%0d", tag, who, g, -e);
        end
    endtask

    // Monitor: pops scoreboard entries as pulses appear.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            cyc++;
            for (int k = 0; k < NTAP; k++) begin
                if (tap_tick[k]) begin
                    if (tseen[k] > 0 && tseen[k] <= 3) begin
                        n_chk++;
                        if (cyc - tlast[k] != (1 << k)) begin
                            n_fail++;
                            $display("FAIL R2 tap %0d: gap %0d expected %0d", k, cyc - tlast[k], 1 << k);
                        end
                    end
                    tlast[k] = cyc;
                    tseen[k]++;
                end
            end
            if (tick_a) begin
                gap_a = cyc - last_a;
                last_a = cyc;
                tot_a++;
                if (qa.size() > 0) judge(ta.pop_front(), gap_a, qa.pop_front(), "clock A");
            end
            if (tick_b) begin
                gap_b = cyc - last_b;
                last_b = cyc;
                tot_b++;
                if (qb.size() > 0) judge(tb.pop_front(), gap_b, qb.pop_front(), "clock B");
            end
        end
    end

    task automatic push(input int h, input string tag, input int v);
        if (h == 0) begin qa.push_back(v); ta.push_back(tag); end
        else        begin qb.push_back(v); tb.push_back(tag); end
    endtask

    // Driver: performs a write and records the gaps it implies.
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag, input int n);
        @(negedge clk);
        #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        for (int h = 0; h < 2; h++) begin
            logic [7:0] nd;
            logic [3:0] ne;
            int per;
            nd = d[h*16 +: 8];
            ne = d[h*16 + 8 +: 4];
            if (a == 8'h00 && (nd != m_div[h] || ne != m_exp[h])) begin
                if (h == 0) begin qa.delete(); ta.delete(); last_a = cyc; end
                else        begin qb.delete(); tb.delete(); last_b = cyc; end
                m_div[h] = nd;
                m_exp[h] = ne;
                if (nd != 8'd0 && ne <= 4'd10) begin
                    per = int'(nd) << ne;
                    push(h, "R6", (ne == 4'd0) ? int'(nd) + 1 : -(per + 1));
                    for (int i = 0; i < n; i++) push(h, tag, per);
                end
            end else if (m_div[h] != 8'd0 && m_exp[h] <= 4'd10) begin
                per = int'(m_div[h]) << m_exp[h];
                for (int i = 0; i < n; i++) push(h, tag, per);
            end
        end
        @(negedge clk);
        #1;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    endtask

    task automatic wait_drain();
        while (qa.size() != 0 || qb.size() != 0) @(negedge clk);
    endtask

    task automatic quiet(input int n, input string tag);
        int ca, cb;
        ca = tot_a;
        cb = tot_b;
        repeat (n) @(negedge clk);
        n_chk++;
        if (tot_a != ca) begin
            n_fail++;
            $display("FAIL %s clock A: %0d pulses expected 0", tag, tot_a - ca);
        end
        n_chk++;
        if (tot_b != cb) begin
            n_fail++;
            $display("FAIL %s clock B: %0d pulses expected 0", tag, tot_b - cb);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < NTAP; k++) begin tlast[k] = 0; tseen[k] = 0; end
        for (int h = 0; h < 2; h++) begin m_div[h] = '0; m_exp[h] = '0; end
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (4) @(negedge clk);
        // R1: all outputs low in reset
        n_chk++;
        if (tap_tick !== '0 || tick_a !== 1'b0 || tick_b !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset outputs: taps %h a %b b %b expected 0 0 0", tap_tick, tick_a, tick_b);
        end
        #1 rst_n = 1'b1;
        quiet(60, "R1");

        wr(8'h00, 32'h0000_0005, "R4", 4);          // A: e0 d5
        wait_drain();
        wr(8'h00, 32'h0001_0303, "R4", 3);          // A: e3 d3, B: e0 d1
        wait_drain();
        wr(8'h00, 32'h0207_0303, "R7", 3);          // A kept, B: e2 d7
        wait_drain();
        wr(8'h04, 32'h0000_0000, "R8", 3);          // wrong address
        wait_drain();
        wr(8'h00, 32'h04FF_FA02, "R3", 2);          // A: e10 d2 with spare bits, B: e4 d255
        wait_drain();
        wr(8'h00, 32'hF000_0A02, "R3", 2);          // A spare bits only, B off
        wait_drain();
        wr(8'h00, 32'h0B05_0300, "R5", 0);          // A divisor 0, B exponent 11
        quiet(3000, "R5");
        wr(8'h00, 32'h0000_0101, "R4", 3);          // A: e1 d1
        wait_drain();
        wr(8'h00, 32'h0000_0000, "R5", 0);          // all off
        quiet(200, "R5");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule